// File: doc/BRIEF.md
# Interrupt Source Pending/Queued Coalescing Controller

This block holds a two-bit state (P for "forwarded, waiting for end-of-interrupt", Q for "triggered again while P was set") for each interrupt source in a small array. It filters trigger events so that a source is sent to the downstream event queue at most once until software acknowledges it. Hardware trigger pulses arrive on a per-source input vector. Each forward is reported as a one-cycle notification carrying the source index.

Software reaches each source through a memory-mapped page on a valid/ready load/store port. The request address is `{trigger_page, source_index, page_offset[11:0]}`. Loads at fixed page offsets read the state or replace it, and every load atomically returns the state as it was before the access. A store at one offset performs end-of-interrupt. A store to the separate trigger page injects a software trigger. When Q is set at end-of-interrupt, the source fires again. When several sources become ready to forward in the same cycle, they drain one per cycle, lowest index first.

Top module: `pq_coalescer`

## Requirements
- R1: For the first cycle after reset, every source holds PQ = 01 (P clear, Q set). In that cycle `fwd_valid` and `resp_valid` are low.
- R2: A trigger moves PQ 00 to 10 and forwards the source. It moves 10 to 11, keeps 11 at 11, and moves 01 to 11. None of these last three forwards the source.
- R3: A load at offset 0x800 returns the state without changing it. The returned word holds P in bit 1 and Q in bit 0, and bits 63:2 are zero.
- R4: Loads at offsets 0xC00, 0xD00, 0xE00 and 0xF00 set PQ to 00, 01, 10 and 11 respectively. Each returns the prior state.
- R5: A load at offset 0x000 is an end-of-interrupt and returns the prior state. If Q was clear, the state becomes 00 with no forward. If Q was set, the state becomes 10 and the source is forwarded.
- R6: A store at offset 0x400 is an end-of-interrupt with the same state effect as R5. It produces no response.
- R7: A store to any offset with the trigger-page address bit set acts as a trigger on the addressed source, with the effect given in R2.
- R8: The following loads return all ones and change no state: a load at any other offset in a state page, a load to the trigger page, and a load to a source index at or above the source count. A store at any offset other than 0x400 in a state page changes nothing.
- R9: When a hardware trigger and an access hit the same source in one cycle, the access is applied first and the trigger is then evaluated on the resulting state.
- R10: A forward appears on `fwd_valid`/`fwd_src` in the cycle after the edge that caused it. Sources that become ready together are forwarded one per cycle, in ascending index order, each exactly once.
- R11: `req_ready` is always high. A load accepted at a clock edge gives `resp_valid` high with its data in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_trig | input | NUM_SRC | Per-source hardware trigger pulses |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Access request accepted (always high) |
| req_write | input | 1 | 1 for store, 0 for load |
| req_addr | input | 1+IDX_W+12 | {trigger page bit, source index, page offset} |
| resp_valid | output | 1 | Load response valid |
| resp_data | output | 64 | Prior state or all ones |
| fwd_valid | output | 1 | A source is forwarded to the event queue |
| fwd_src | output | IDX_W | Index of the forwarded source |

## Verification
The bench builds the block with NUM_SRC = 6. This source count is not a power of two, so the three-bit index field can name sources 6 and 7, which do not exist. The bench uses those indices to check the all-ones, no-change path. Six sources also leave enough room for three to be released in one cycle, so the ascending one-per-cycle drain is exercised. The bench also checks the ordering when an access and a hardware trigger hit the same source in one cycle.

// File: rtl/pq_coalescer_pkg.sv
package pq_coalescer_pkg;

    localparam int OFF_W  = 12;
    localparam int DATA_W = 64;

    localparam logic [OFF_W-1:0] OFF_LD_EOI = 12'h000;
    localparam logic [OFF_W-1:0] OFF_ST_EOI = 12'h400;
    localparam logic [OFF_W-1:0] OFF_PEEK   = 12'h800;
    localparam logic [OFF_W-1:0] OFF_SET00  = 12'hC00;
    localparam logic [OFF_W-1:0] OFF_SET01  = 12'hD00;
    localparam logic [OFF_W-1:0] OFF_SET10  = 12'hE00;
    localparam logic [OFF_W-1:0] OFF_SET11  = 12'hF00;

    typedef struct packed {
        logic p;
        logic q;
    } pq_t;

    localparam pq_t PQ_OFF = '{p: 1'b0, q: 1'b1};

    typedef enum logic [2:0] {
        OP_NONE,
        OP_PEEK,
        OP_EOI,
        OP_SET,
        OP_TRIG,
        OP_BAD
    } op_e;

    typedef struct packed {
        op_e op;
        pq_t set_val;
    } cmd_t;

    typedef struct packed {
        pq_t  st;
        logic fwd;
    } step_t;

    function automatic step_t apply_trigger(pq_t s);
        step_t r;
        if (!s.p && !s.q) begin
            r.st  = '{p: 1'b1, q: 1'b0};
            r.fwd = 1'b1;
        end else begin
            r.st  = '{p: 1'b1, q: 1'b1};
            r.fwd = 1'b0;
        end
        return r;
    endfunction

    function automatic step_t apply_eoi(pq_t s);
        step_t r;
        if (s.q) begin
            r = apply_trigger('{p: 1'b0, q: 1'b0});
        end else begin
            r.st  = '{p: 1'b0, q: 1'b0};
            r.fwd = 1'b0;
        end
        return r;
    endfunction

    function automatic cmd_t decode_offset(logic is_write, logic [OFF_W-1:0] off);
        cmd_t c;
        c.op      = OP_NONE;
        c.set_val = '0;
        if (is_write) begin
            if (off == OFF_ST_EOI) c.op = OP_EOI;
        end else begin
            unique case (off)
                OFF_LD_EOI: c.op = OP_EOI;
                OFF_PEEK:   c.op = OP_PEEK;
                OFF_SET00:  begin c.op = OP_SET; c.set_val = 2'b00; end
                OFF_SET01:  begin c.op = OP_SET; c.set_val = 2'b01; end
                OFF_SET10:  begin c.op = OP_SET; c.set_val = 2'b10; end
                OFF_SET11:  begin c.op = OP_SET; c.set_val = 2'b11; end
                default:    c.op = OP_BAD;
            endcase
        end
        return c;
    endfunction

endpackage

// File: rtl/pq_access_decode.sv
module pq_access_decode
    import pq_coalescer_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int IDX_W   = $clog2(NUM_SRC),
    localparam int ADDR_W = 1 + IDX_W + OFF_W
) (
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    output cmd_t              cmd,
    output logic [IDX_W-1:0]  src,
    output logic [NUM_SRC-1:0] sel_vec
);

    logic             trig_page;
    logic [OFF_W-1:0] off;
    logic             in_range;

    assign trig_page = req_addr[ADDR_W-1];
    assign src       = req_addr[OFF_W +: IDX_W];
    assign off       = req_addr[OFF_W-1:0];

    generate
        if (NUM_SRC == (1 << IDX_W)) begin : g_full
            assign in_range = 1'b1;
        end else begin : g_part
            assign in_range = (src < IDX_W'(NUM_SRC));
        end
    endgenerate

    always_comb begin
        cmd = '{op: OP_NONE, set_val: 2'b00};
        if (req_valid) begin
            if (!in_range) begin
                cmd.op = req_write ? OP_NONE : OP_BAD;
            end else if (trig_page) begin
                cmd.op = req_write ? OP_TRIG : OP_BAD;
            end else begin
                cmd = decode_offset(req_write, off);
            end
        end
    end

    always_comb begin
        sel_vec = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            sel_vec[i] = in_range && (src == IDX_W'(i)) &&
                         (cmd.op inside {OP_EOI, OP_SET, OP_TRIG});
        end
    end

endmodule

// File: rtl/pq_source_cell.sv
module pq_source_cell
    import pq_coalescer_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sel,
    input  cmd_t cmd,
    input  logic trig,
    output pq_t  state,
    output logic fwd_new
);

    pq_t   mid, nxt;
    step_t s_acc, s_hw;
    logic  fwd_acc;

    always_comb begin
        mid     = state;
        fwd_acc = 1'b0;
        s_acc   = '0;
        if (sel) begin
            unique case (cmd.op)
                OP_EOI: begin
                    s_acc   = apply_eoi(state);
                    mid     = s_acc.st;
                    fwd_acc = s_acc.fwd;
                end
                OP_SET: mid = cmd.set_val;
                OP_TRIG: begin
                    s_acc   = apply_trigger(state);
                    mid     = s_acc.st;
                    fwd_acc = s_acc.fwd;
                end
                default: mid = state;
            endcase
        end
        s_hw = apply_trigger(mid);
        if (trig) begin
            nxt     = s_hw.st;
            fwd_new = fwd_acc | s_hw.fwd;
        end else begin
            nxt     = mid;
            fwd_new = fwd_acc;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state <= PQ_OFF;
        else     state <= nxt;
    end

endmodule

// File: rtl/pq_forward_arb.sv
module pq_forward_arb #(
    parameter int NUM_SRC = 8,
    parameter int IDX_W   = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] fwd_set,
    output logic               fwd_valid,
    output logic [IDX_W-1:0]   fwd_src
);

    logic [NUM_SRC-1:0] pend;
    logic [NUM_SRC-1:0] grant;

    always_comb begin
        grant     = '0;
        fwd_valid = 1'b0;
        fwd_src   = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (pend[i]) begin
                grant     = '0;
                grant[i]  = 1'b1;
                fwd_valid = 1'b1;
                fwd_src   = IDX_W'(i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) pend <= '0;
        else     pend <= (pend & ~grant) | fwd_set;
    end

endmodule

// File: rtl/pq_coalescer.sv
module pq_coalescer
    import pq_coalescer_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int IDX_W   = $clog2(NUM_SRC),
    localparam int ADDR_W = 1 + IDX_W + OFF_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] hw_trig,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  req_addr,
    output logic               resp_valid,
    output logic [DATA_W-1:0]  resp_data,
    output logic               fwd_valid,
    output logic [IDX_W-1:0]   fwd_src
);

    cmd_t                 cmd;
    logic [IDX_W-1:0]     src;
    logic [NUM_SRC-1:0]   sel_vec;
    logic [NUM_SRC-1:0]   fwd_set;
    logic [2*NUM_SRC-1:0] state_flat;
    pq_t                  prior;
    logic [DATA_W-1:0]    resp_next;

    assign req_ready = 1'b1;

    pq_access_decode #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_decode (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .cmd       (cmd),
        .src       (src),
        .sel_vec   (sel_vec)
    );

    generate
        for (genvar g = 0; g < NUM_SRC; g++) begin : g_cell
            pq_t cell_state;
            pq_source_cell u_cell (
                .clk     (clk),
                .rst     (rst),
                .sel     (sel_vec[g]),
                .cmd     (cmd),
                .trig    (hw_trig[g]),
                .state   (cell_state),
                .fwd_new (fwd_set[g])
            );
            assign state_flat[2*g +: 2] = cell_state;
        end
    endgenerate

    pq_forward_arb #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_arb (
        .clk       (clk),
        .rst       (rst),
        .fwd_set   (fwd_set),
        .fwd_valid (fwd_valid),
        .fwd_src   (fwd_src)
    );

    always_comb begin
        prior = PQ_OFF;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (src == IDX_W'(i)) prior = state_flat[2*i +: 2];
        end
        if (cmd.op inside {OP_PEEK, OP_EOI, OP_SET})
            resp_next = {{(DATA_W-2){1'b0}}, prior};
        else
            resp_next = '1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_valid <= 1'b0;
            resp_data  <= '0;
        end else begin
            resp_valid <= req_valid && !req_write;
            if (req_valid && !req_write) resp_data <= resp_next;
        end
    end

endmodule

// File: rtl/pq_coalescer_chk.sv
module pq_coalescer_chk #(
    parameter int NUM_SRC = 8,
    parameter int IDX_W   = $clog2(NUM_SRC)
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 req_valid,
    input logic                 req_write,
    input logic                 resp_valid,
    input logic [63:0]          resp_data,
    input logic                 fwd_valid,
    input logic [IDX_W-1:0]     fwd_src,
    input logic [2*NUM_SRC-1:0] state_flat,
    input logic [NUM_SRC-1:0]   sel_vec
);

    assert_reset_off_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (state_flat == {NUM_SRC{2'b01}} && !fwd_valid && !resp_valid));

    assert_resp_after_load_R11: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> ($past(req_valid) && !$past(req_write)));

    assert_upper_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_data != '1) |-> (resp_data[63:2] == '0));

    assert_fwd_in_range_R10: assert property (@(posedge clk) disable iff (rst)
        fwd_valid |-> (int'(fwd_src) < NUM_SRC));

    generate
        for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
            assert_sticky_11_R2: assert property (@(posedge clk) disable iff (rst)
                (!$past(rst) && $past(state_flat[2*i +: 2]) == 2'b11 && !$past(sel_vec[i]))
                |-> (state_flat[2*i +: 2] == 2'b11));
        end
    endgenerate

endmodule

bind pq_coalescer pq_coalescer_chk #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .resp_valid (resp_valid),
    .resp_data  (resp_data),
    .fwd_valid  (fwd_valid),
    .fwd_src    (fwd_src),
    .state_flat (state_flat),
    .sel_vec    (sel_vec)
);

// File: tb/test_pq_coalescer.sv
module test_pq_coalescer;

    localparam int N   = 6;
    localparam int IW  = 3;
    localparam int AW  = 1 + IW + 12;
    localparam logic [63:0] ONES = '1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  hw_trig = '0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          resp_valid;
    logic [63:0]   resp_data;
    logic          fwd_valid;
    logic [IW-1:0] fwd_src;

    int tests = 0;
    int fails = 0;
    int fwd_cnt [8];
    int fwd_log [32];
    int log_n = 0;

    always #10 clk = ~clk;

    pq_coalescer #(.NUM_SRC(N)) i_pq_coalescer (
        .clk(clk), .rst(rst), .hw_trig(hw_trig),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .resp_valid(resp_valid), .resp_data(resp_data),
        .fwd_valid(fwd_valid), .fwd_src(fwd_src)
    );

    always @(negedge clk) begin
        if (!rst && fwd_valid) begin
            fwd_cnt[fwd_src] = fwd_cnt[fwd_src] + 1;
            if (log_n < 32) fwd_log[log_n] = int'(fwd_src);
            log_n = log_n + 1;
        end
    end

    function automatic logic [AW-1:0] mk(input logic tp, input int idx, input logic [11:0] off);
        return {tp, IW'(idx), off};
    endfunction

    task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic load(input logic [AW-1:0] a, output logic [63:0] d, output logic v);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        d = resp_data; v = resp_valid;
        #1;
    endtask

    task automatic store(input logic [AW-1:0] a, output logic v);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        v = resp_valid;
        #1;
    endtask

    task automatic pulse(input logic [N-1:0] m);
        @(negedge clk);
        hw_trig = m;
        @(negedge clk);
        hw_trig = '0;
        #1;
    endtask

    task automatic peek(input int idx, output logic [63:0] d);
        logic v;
        load(mk(1'b0, idx, 12'h800), d, v);
    endtask

    task automatic t_reset();
        logic [63:0] d;
        logic v;
        chk("R1 resp_valid low after reset", 64'(resp_valid), 64'd0);
        chk("R11 req_ready high", 64'(req_ready), 64'd1);
        for (int i = 0; i < N; i++) begin
            load(mk(1'b0, i, 12'h800), d, v);
            chk($sformatf("R1 source %0d resets to 01", i), d, 64'd1);
            chk("R11 resp_valid after load", 64'(v), 64'd1);
        end
        chk("R1 no forward after reset", 64'(log_n), 64'd0);
    endtask

    task automatic t_trigger();
        logic [63:0] d;
        logic v;
        pulse(6'b000001);
        peek(0, d);
        chk("R2 01 trigger gives 11", d, 64'd3);
        chk("R2 01 trigger no forward", 64'(fwd_cnt[0]), 64'd0);
        load(mk(1'b0, 1, 12'hC00), d, v);
        chk("R4 set00 returns prior 01", d, 64'd1);
        peek(1, d);
        chk("R4 state now 00", d, 64'd0);
        pulse(6'b000010);
        chk("R2 00 trigger forwards", 64'(fwd_cnt[1]), 64'd1);
        peek(1, d);
        chk("R2 00 trigger gives 10", d, 64'd2);
        pulse(6'b000010);
        peek(1, d);
        chk("R2 10 trigger gives 11", d, 64'd3);
        pulse(6'b000010);
        peek(1, d);
        chk("R2 11 trigger stays 11", d, 64'd3);
        chk("R2 no extra forward while P", 64'(fwd_cnt[1]), 64'd1);
    endtask

    task automatic t_load_eoi();
        logic [63:0] d;
        logic v;
        load(mk(1'b0, 1, 12'h000), d, v);
        chk("R5 eoi returns prior 11", d, 64'd3);
        chk("R5 eoi with Q forwards", 64'(fwd_cnt[1]), 64'd2);
        peek(1, d);
        chk("R5 eoi with Q gives 10", d, 64'd2);
        load(mk(1'b0, 1, 12'h000), d, v);
        chk("R5 eoi returns prior 10", d, 64'd2);
        peek(1, d);
        chk("R5 eoi without Q gives 00", d, 64'd0);
        chk("R5 eoi without Q no forward", 64'(fwd_cnt[1]), 64'd2);
    endtask

    task automatic t_store_eoi();
        logic [63:0] d;
        logic v;
        load(mk(1'b0, 2, 12'hE00), d, v);
        chk("R4 set10 returns prior 01", d, 64'd1);
        store(mk(1'b0, 2, 12'h400), v);
        chk("R6 store gives no response", 64'(v), 64'd0);
        peek(2, d);
        chk("R6 store eoi gives 00", d, 64'd0);
        chk("R6 store eoi no forward", 64'(fwd_cnt[2]), 64'd0);
        load(mk(1'b0, 2, 12'hF00), d, v);
        chk("R4 set11 returns prior 00", d, 64'd0);
        store(mk(1'b0, 2, 12'h400), v);
        chk("R6 store eoi with Q forwards", 64'(fwd_cnt[2]), 64'd1);
        peek(2, d);
        chk("R6 store eoi with Q gives 10", d, 64'd2);
        load(mk(1'b0, 2, 12'hD00), d, v);
        chk("R4 set01 returns prior 10", d, 64'd2);
        peek(2, d);
        chk("R4 state now 01", d, 64'd1);
    endtask

    task automatic t_sw_trigger();
        logic [63:0] d;
        logic v;
        load(mk(1'b0, 3, 12'hC00), d, v);
        store(mk(1'b1, 3, 12'h000), v);
        chk("R7 trigger page forwards", 64'(fwd_cnt[3]), 64'd1);
        peek(3, d);
        chk("R7 trigger page gives 10", d, 64'd2);
        store(mk(1'b1, 3, 12'h7F8), v);
        peek(3, d);
        chk("R7 second sw trigger gives 11", d, 64'd3);
    endtask

    task automatic t_bad();
        logic [63:0] d;
        logic v;
        load(mk(1'b0, 4, 12'h400), d, v);
        chk("R8 load at 0x400 all ones", d, ONES);
        load(mk(1'b0, 4, 12'h123), d, v);
        chk("R8 load at 0x123 all ones", d, ONES);
        load(mk(1'b1, 4, 12'h800), d, v);
        chk("R8 load on trigger page all ones", d, ONES);
        load(mk(1'b0, 7, 12'h800), d, v);
        chk("R8 index 7 all ones", d, ONES);
        load(mk(1'b0, 6, 12'hC00), d, v);
        chk("R8 index 6 all ones", d, ONES);
        store(mk(1'b0, 4, 12'hC00), v);
        store(mk(1'b0, 4, 12'h000), v);
        peek(4, d);
        chk("R8 ignored accesses leave 01", d, 64'd1);
        chk("R8 ignored accesses no forward", 64'(fwd_cnt[4]), 64'd0);
    endtask

    task automatic t_same_cycle();
        logic [63:0] d;
        pulse(6'b100000);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = mk(1'b0, 5, 12'hC00);
        hw_trig = 6'b100000;
        @(negedge clk);
        req_valid = 1'b0; hw_trig = '0;
        d = resp_data;
        #1;
        chk("R9 access returns prior 11", d, 64'd3);
        chk("R9 set00 then trigger forwards", 64'(fwd_cnt[5]), 64'd1);
        peek(5, d);
        chk("R9 final state 10", d, 64'd2);
    endtask

    task automatic t_multi();
        logic [63:0] d;
        logic v;
        int base;
        load(mk(1'b0, 0, 12'hC00), d, v);
        load(mk(1'b0, 2, 12'hC00), d, v);
        load(mk(1'b0, 4, 12'hC00), d, v);
        base = log_n;
        @(negedge clk);
        hw_trig = 6'b010101;
        @(negedge clk);
        hw_trig = '0;
        repeat (4) @(negedge clk);
        #1;
        chk("R10 three forwards", 64'(log_n - base), 64'd3);
        chk("R10 first is 0", 64'(fwd_log[base]), 64'd0);
        chk("R10 second is 2", 64'(fwd_log[base+1]), 64'd2);
        chk("R10 third is 4", 64'(fwd_log[base+2]), 64'd4);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) fwd_cnt[i] = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        t_reset();
        t_trigger();
        t_load_eoi();
        t_store_eoi();
        t_sw_trigger();
        t_bad();
        t_same_cycle();
        t_multi();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule